// File: doc/BRIEF.md
# Serial Link Bring-Up Sequencer

This block drives a group of 8b/10b serial channels from power-on to a synchronised link without software. It keeps the transceiver's hardware reset low while the surrounding fabric is still configuring. Once configuration is complete, it runs a fixed start-up recipe as transactions on a simple request/acknowledge register bus. The recipe first clears sticky status by reading every channel's alarm register once. It then programs the per-quad and per-channel control registers, pulses the global soft reset and waits for the receive PLLs to settle. Finally it polls each channel's lock indicator.

If every channel locks and 8b/10b mode is selected, the block emits the link synchronisation ordered set on a K/data byte port. It then raises a done flag. If a channel stays unlocked for too many polls, the block raises an error flag instead and goes silent. Register addresses, field positions, the wait length and the poll limit are all parameters. The bus slave, the encoder and the PLLs sit outside the block.

Top module: `link_bringup_seq`

## Requirements
- R1: `hw_rst_n_o` is 0 from reset for as long as `cfg_done_i` is 0, and it goes to 1 the cycle after `cfg_done_i` is seen high. It then stays 1. No bus request is made while it is 0.
- R2: The first bus operations are one read of every channel's alarm register, in channel order g = 0..NQUAD*NCH-1. The address is CH_BASE + (g/NCH)*QUAD_STRIDE + (g%NCH)*CH_STRIDE + ALARM_OFS. The returned data is discarded, so an unlocked value here causes no retry and no error.
- R3: Next, for each quad q, two writes are made. The first goes to QCTL_BASE + q*QCTL_STRIDE with bits [LTD_LSB+NCH-1:LTD_LSB] (lock to data) and [ALIGN_LSB+NCH-1:ALIGN_LSB] (comma alignment) all 1. The second goes to that address + 1, with bits [LPBK_LSB+NCH-1:LPBK_LSB] all equal to `loopback_i`. All other bits are 0.
- R4: Next, for each channel g, a transmit config write is made to the channel base + TXCFG_OFS and a receive config write to the channel base + RXCFG_OFS. Each write carries bit ENC_BIT = `enc_mode_i` and bit HR_BIT = `half_rate_i`, with all other bits 0.
- R5: Next come four writes to GRST_ADDR with bit GRST_BIT equal to 1, 1, 0, 0 in that order. All other bits are 0.
- R6: After the last reset write, exactly WAIT_CYCLES clock cycles pass with no bus request. The first lock poll is then issued.
- R7: Lock polling reads the alarm registers in channel order. Bit LOCK_BIT = 1 means locked and moves on to the next channel. A 0 repeats the read of the same channel.
- R8: If MAX_POLLS consecutive reads of one channel return unlocked, `err_o` goes to 1 and stays there. After that there are no further bus requests and no transmit characters.
- R9: When all channels lock and `enc_mode_i` is 1, the block sends twelve characters on consecutive cycles. The group K28.5 (`tx_k_o`=1, 0xBC), D21.4 (0x95), D21.5 (0xB5), D21.5 (0xB5) is sent three times. `done_o` is then set.
- R10: When all channels lock and `enc_mode_i` is 0, no character is sent and `done_o` is set directly.
- R11: A bus request that is not acknowledged is held, with address, direction and write data unchanged, until `bus_ack_i` is seen.
- R12: `done_o` and `err_o` are never 1 together, and each stays 1 once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_done_i | input | 1 | Fabric configuration finished |
| loopback_i | input | 1 | Request serial loopback on all channels |
| half_rate_i | input | 1 | Request half-rate transmit and receive |
| enc_mode_i | input | 1 | 8b/10b mode enabled |
| hw_rst_n_o | output | 1 | Active-low hardware reset to the transceiver |
| bus_req_o | output | 1 | Register bus request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | AW | Register address |
| bus_wdata_o | output | DW | Write data |
| bus_ack_i | input | 1 | Transaction accepted this cycle |
| bus_rdata_i | input | DW | Read data, valid with acknowledge |
| tx_valid_o | output | 1 | Transmit character valid |
| tx_k_o | output | 1 | Character is a control (K) code |
| tx_data_o | output | 8 | Character byte |
| done_o | output | 1 | Link brought up |
| err_o | output | 1 | A channel failed to lock |

## Verification
The bench acknowledges bus requests with gaps. A sequencer that advanced on the request alone would then skip or duplicate operations. The clearing reads return unlocked data, so a design that treated them as polls would insert extra reads.

One channel is made to lock on exactly the last permitted poll, and another never locks. A poll counter that is off by one would either raise a false error or allow a fifth read. The idle gap after the reset writes is counted exactly, and that count exposes a timer that expires a cycle early or late.

A run with 8b/10b mode off checks that no sync characters leak out. The scoreboard sees every bus transaction and every character, so any transaction issued after an error is reported.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

   typedef enum logic [3:0] {
      ST_HOLD,
      ST_CLEAR,
      ST_QUAD,
      ST_CHAN,
      ST_GRST,
      ST_WAIT,
      ST_POLL,
      ST_SYNC,
      ST_DONE,
      ST_FAIL
   } lbs_state_e;

   // control code and data characters of the synchronisation group
   localparam logic [7:0] CHAR_K28_5 = 8'hBC;
   localparam logic [7:0] CHAR_D21_4 = 8'h95;
   localparam logic [7:0] CHAR_D21_5 = 8'hB5;

   function automatic int lbs_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lbs_wait_timer.sv
module lbs_wait_timer #(
   parameter int CYCLES = 300000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expired_o
);
   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run_i) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/lbs_sync_gen.sv
module lbs_sync_gen
   import lbs_pkg::*;
(
   input  logic [1:0] pos_i,
   output logic       k_o,
   output logic [7:0] data_o
);
   always_comb begin
      k_o = 1'b0;
      unique case (pos_i)
         2'd0: begin
            k_o    = 1'b1;
            data_o = CHAR_K28_5;
         end
         2'd1:    data_o = CHAR_D21_4;
         default: data_o = CHAR_D21_5;
      endcase
   end
endmodule

// File: rtl/lbs_op_gen.sv
module lbs_op_gen
   import lbs_pkg::*;
#(
   parameter int          AW          = 16,
   parameter int          DW          = 8,
   parameter int          NCH         = 4,
   parameter int          IDXW        = 5,
   parameter int unsigned QCTL_BASE   = 32'h0800,
   parameter int unsigned QCTL_STRIDE = 32'h0100,
   parameter int unsigned CH_BASE     = 32'h0000,
   parameter int unsigned QUAD_STRIDE = 32'h0100,
   parameter int unsigned CH_STRIDE   = 32'h0010,
   parameter int unsigned ALARM_OFS   = 0,
   parameter int unsigned TXCFG_OFS   = 2,
   parameter int unsigned RXCFG_OFS   = 3,
   parameter int unsigned GRST_ADDR   = 32'h0A00,
   parameter int          LTD_LSB     = 0,
   parameter int          ALIGN_LSB   = 4,
   parameter int          LPBK_LSB    = 0,
   parameter int          ENC_BIT     = 3,
   parameter int          HR_BIT      = 0,
   parameter int          GRST_BIT    = 0
) (
   input  lbs_state_e      state_i,
   input  logic [IDXW-1:0] idx_i,
   input  logic            loopback_i,
   input  logic            half_rate_i,
   input  logic            enc_mode_i,
   output logic            req_o,
   output logic            we_o,
   output logic [AW-1:0]   addr_o,
   output logic [DW-1:0]   wdata_o
);
   localparam int CHW = $clog2(NCH);

   function automatic logic [DW-1:0] field_ones(input int lsb);
      logic [DW-1:0] m;
      m = '0;
      for (int i = 0; i < NCH; i++) m[lsb+i] = 1'b1;
      return m;
   endfunction

   localparam logic [DW-1:0] QCTL0_VAL = field_ones(LTD_LSB) | field_ones(ALIGN_LSB);

   // one loopback enable per lane, replicated from the single option
   logic [NCH-1:0] lpbk_lanes;
   for (genvar ln = 0; ln < NCH; ln++) begin : g_lane
      assign lpbk_lanes[ln] = loopback_i;
   end

   logic [DW-1:0] qctl1_val;
   assign qctl1_val = DW'(lpbk_lanes) << LPBK_LSB;

   int unsigned sel_u, gch_u, quad_u, lane_u, ofs_u;

   always_comb begin
      sel_u   = 32'(idx_i);
      gch_u   = (state_i == ST_CHAN) ? (sel_u >> 1) : sel_u;
      quad_u  = gch_u >> CHW;
      lane_u  = gch_u & (NCH - 1);
      ofs_u   = sel_u[0] ? RXCFG_OFS : TXCFG_OFS;
      req_o   = 1'b0;
      we_o    = 1'b0;
      addr_o  = '0;
      wdata_o = '0;
      case (state_i)
         ST_CLEAR, ST_POLL: begin
            req_o  = 1'b1;
            addr_o = AW'(CH_BASE + quad_u * QUAD_STRIDE + lane_u * CH_STRIDE + ALARM_OFS);
         end
         ST_QUAD: begin
            req_o   = 1'b1;
            we_o    = 1'b1;
            addr_o  = AW'(QCTL_BASE + (sel_u >> 1) * QCTL_STRIDE + (sel_u & 1));
            wdata_o = sel_u[0] ? qctl1_val : QCTL0_VAL;
         end
         ST_CHAN: begin
            req_o            = 1'b1;
            we_o             = 1'b1;
            addr_o           = AW'(CH_BASE + quad_u * QUAD_STRIDE + lane_u * CH_STRIDE + ofs_u);
            wdata_o[ENC_BIT] = enc_mode_i;
            wdata_o[HR_BIT]  = half_rate_i;
         end
         ST_GRST: begin
            req_o             = 1'b1;
            we_o              = 1'b1;
            addr_o            = AW'(GRST_ADDR);
            wdata_o[GRST_BIT] = (sel_u < 2);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
   import lbs_pkg::*;
#(
   parameter int          AW          = 16,
   parameter int          DW          = 8,
   parameter int          NQUAD       = 2,
   parameter int          NCH         = 4,
   parameter int          WAIT_CYCLES = 300000,
   parameter int          MAX_POLLS   = 16,
   parameter int          SYNC_REPEAT = 3,
   parameter int unsigned QCTL_BASE   = 32'h0800,
   parameter int unsigned QCTL_STRIDE = 32'h0100,
   parameter int unsigned CH_BASE     = 32'h0000,
   parameter int unsigned QUAD_STRIDE = 32'h0100,
   parameter int unsigned CH_STRIDE   = 32'h0010,
   parameter int unsigned ALARM_OFS   = 0,
   parameter int unsigned TXCFG_OFS   = 2,
   parameter int unsigned RXCFG_OFS   = 3,
   parameter int unsigned GRST_ADDR   = 32'h0A00,
   parameter int          LTD_LSB     = 0,
   parameter int          ALIGN_LSB   = 4,
   parameter int          LPBK_LSB    = 0,
   parameter int          ENC_BIT     = 3,
   parameter int          HR_BIT      = 0,
   parameter int          LOCK_BIT    = 0,
   parameter int          GRST_BIT    = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_done_i,
   input  logic          loopback_i,
   input  logic          half_rate_i,
   input  logic          enc_mode_i,
   output logic          hw_rst_n_o,
   output logic          bus_req_o,
   output logic          bus_we_o,
   output logic [AW-1:0] bus_addr_o,
   output logic [DW-1:0] bus_wdata_o,
   input  logic          bus_ack_i,
   input  logic [DW-1:0] bus_rdata_i,
   output logic          tx_valid_o,
   output logic          tx_k_o,
   output logic [7:0]    tx_data_o,
   output logic          done_o,
   output logic          err_o
);
   localparam int NTOT  = NQUAD * NCH;
   localparam int SPAN  = lbs_max(lbs_max(2 * NTOT, 4 * SYNC_REPEAT), 2 * NQUAD);
   localparam int IDXW  = $clog2(SPAN) + 1;
   localparam int PCW   = $clog2(MAX_POLLS) + 1;
   localparam logic [IDXW-1:0] LAST_CH   = IDXW'(NTOT - 1);
   localparam logic [IDXW-1:0] LAST_QUAD = IDXW'(2 * NQUAD - 1);
   localparam logic [IDXW-1:0] LAST_CFG  = IDXW'(2 * NTOT - 1);
   localparam logic [IDXW-1:0] LAST_GRST = IDXW'(3);
   localparam logic [IDXW-1:0] LAST_SYNC = IDXW'(4 * SYNC_REPEAT - 1);
   localparam logic [PCW-1:0]  LAST_POLL = PCW'(MAX_POLLS - 1);

   // elaboration-time parameter checks
   if (NCH < 2 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
      $error("NCH must be a power of two, at least 2");
   end
   if (NQUAD < 1 || MAX_POLLS < 1 || WAIT_CYCLES < 1 || SYNC_REPEAT < 1) begin : g_bad_count
      $error("NQUAD, MAX_POLLS, WAIT_CYCLES and SYNC_REPEAT must be positive");
   end
   if (LTD_LSB + NCH > DW || ALIGN_LSB + NCH > DW || LPBK_LSB + NCH > DW) begin : g_bad_field
      $error("per-lane control field exceeds data width");
   end
   if (ENC_BIT >= DW || HR_BIT >= DW || LOCK_BIT >= DW || GRST_BIT >= DW) begin : g_bad_bit
      $error("single-bit field position exceeds data width");
   end

   lbs_state_e      state_q;
   logic [IDXW-1:0] idx_q;
   logic [PCW-1:0]  poll_q;
   logic            accept;
   logic            wait_done;
   logic            unused_rdata;

   assign accept       = bus_req_o && bus_ack_i;
   assign unused_rdata = ^bus_rdata_i;

   lbs_op_gen #(
      .AW(AW), .DW(DW), .NCH(NCH), .IDXW(IDXW),
      .QCTL_BASE(QCTL_BASE), .QCTL_STRIDE(QCTL_STRIDE),
      .CH_BASE(CH_BASE), .QUAD_STRIDE(QUAD_STRIDE), .CH_STRIDE(CH_STRIDE),
      .ALARM_OFS(ALARM_OFS), .TXCFG_OFS(TXCFG_OFS), .RXCFG_OFS(RXCFG_OFS),
      .GRST_ADDR(GRST_ADDR), .LTD_LSB(LTD_LSB), .ALIGN_LSB(ALIGN_LSB),
      .LPBK_LSB(LPBK_LSB), .ENC_BIT(ENC_BIT), .HR_BIT(HR_BIT), .GRST_BIT(GRST_BIT)
   ) u_op_gen (
      .state_i     (state_q),
      .idx_i       (idx_q),
      .loopback_i  (loopback_i),
      .half_rate_i (half_rate_i),
      .enc_mode_i  (enc_mode_i),
      .req_o       (bus_req_o),
      .we_o        (bus_we_o),
      .addr_o      (bus_addr_o),
      .wdata_o     (bus_wdata_o)
   );

   lbs_wait_timer #(.CYCLES(WAIT_CYCLES)) u_wait (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (state_q == ST_WAIT),
      .expired_o (wait_done)
   );

   lbs_sync_gen u_sync (
      .pos_i  (idx_q[1:0]),
      .k_o    (tx_k_o),
      .data_o (tx_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HOLD;
         idx_q   <= '0;
         poll_q  <= '0;
      end else begin
         case (state_q)
            ST_HOLD: if (cfg_done_i) begin
               state_q <= ST_CLEAR;
               idx_q   <= '0;
            end
            ST_CLEAR: if (accept) begin
               idx_q <= (idx_q == LAST_CH) ? '0 : idx_q + 1'b1;
               if (idx_q == LAST_CH) state_q <= ST_QUAD;
            end
            ST_QUAD: if (accept) begin
               idx_q <= (idx_q == LAST_QUAD) ? '0 : idx_q + 1'b1;
               if (idx_q == LAST_QUAD) state_q <= ST_CHAN;
            end
            ST_CHAN: if (accept) begin
               idx_q <= (idx_q == LAST_CFG) ? '0 : idx_q + 1'b1;
               if (idx_q == LAST_CFG) state_q <= ST_GRST;
            end
            ST_GRST: if (accept) begin
               idx_q <= (idx_q == LAST_GRST) ? '0 : idx_q + 1'b1;
               if (idx_q == LAST_GRST) state_q <= ST_WAIT;
            end
            ST_WAIT: if (wait_done) begin
               state_q <= ST_POLL;
               idx_q   <= '0;
               poll_q  <= '0;
            end
            ST_POLL: if (accept) begin
               if (bus_rdata_i[LOCK_BIT]) begin
                  poll_q <= '0;
                  if (idx_q == LAST_CH) begin
                     idx_q   <= '0;
                     state_q <= enc_mode_i ? ST_SYNC : ST_DONE;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end else if (poll_q == LAST_POLL) begin
                  state_q <= ST_FAIL;
               end else begin
                  poll_q <= poll_q + 1'b1;
               end
            end
            ST_SYNC: begin
               idx_q <= (idx_q == LAST_SYNC) ? '0 : idx_q + 1'b1;
               if (idx_q == LAST_SYNC) state_q <= ST_DONE;
            end
            default: ;
         endcase
      end
   end

   assign hw_rst_n_o = (state_q != ST_HOLD);
   assign tx_valid_o = (state_q == ST_SYNC);
   assign done_o     = (state_q == ST_DONE);
   assign err_o      = (state_q == ST_FAIL);
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_done_i,
   input logic          hw_rst_n_o,
   input logic          bus_req_o,
   input logic          bus_we_o,
   input logic [AW-1:0] bus_addr_o,
   input logic [DW-1:0] bus_wdata_o,
   input logic          bus_ack_i,
   input logic          tx_valid_o,
   input logic          done_o,
   input logic          err_o
);
   assert_no_bus_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_rst_n_o |-> !bus_req_o);

   assert_release_after_cfg_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hw_rst_n_o) |-> $past(cfg_done_i));

   assert_release_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hw_rst_n_o |=> hw_rst_n_o);

   assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_we_o)
                                     && $stable(bus_addr_o) && $stable(bus_wdata_o)));

   assert_quiet_after_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!bus_req_o && !tx_valid_o));

   assert_tx_not_during_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_o |-> !bus_req_o);

   assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));

   assert_done_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> done_o);

   assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);
endmodule

bind link_bringup_seq lbs_checker #(.AW(AW), .DW(DW)) u_lbs_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_done_i  (cfg_done_i),
   .hw_rst_n_o  (hw_rst_n_o),
   .bus_req_o   (bus_req_o),
   .bus_we_o    (bus_we_o),
   .bus_addr_o  (bus_addr_o),
   .bus_wdata_o (bus_wdata_o),
   .bus_ack_i   (bus_ack_i),
   .tx_valid_o  (tx_valid_o),
   .done_o      (done_o),
   .err_o       (err_o)
);

// File: tb/link_bringup_seq_bench.sv
module link_bringup_seq_bench;
   localparam int AW = 16, DW = 8, NQUAD = 2, NCH = 4, NTOT = 8;
   localparam int WAITC = 40, MAXP = 4;
   localparam int QCTL_BASE = 'h0800, QCTL_STRIDE = 'h0100;
   localparam int CH_BASE = 0, QUAD_STRIDE = 'h0100, CH_STRIDE = 'h0010;
   localparam int ALARM_OFS = 0, TXCFG_OFS = 2, RXCFG_OFS = 3, GRST_ADDR = 'h0A00;
   localparam int ENC_BIT = 3, HR_BIT = 0, LOCK_BIT = 0, GRST_BIT = 0;

   typedef struct {
      logic          we;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      string         tag;
   } txn_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_done = 1'b0, loopback = 1'b0, half_rate = 1'b0, enc_mode = 1'b0;
   logic bus_ack = 1'b0;
   logic [DW-1:0] bus_rdata = '0;
   logic hw_rst_n_o, bus_req_o, bus_we_o, tx_valid_o, tx_k_o, done_o, err_o;
   logic [AW-1:0] bus_addr_o;
   logic [DW-1:0] bus_wdata_o;
   logic [7:0] tx_data_o;

   always #5 clk = ~clk;

   link_bringup_seq #(.WAIT_CYCLES(WAITC), .MAX_POLLS(MAXP)) u_link_bringup_seq (
      .clk(clk), .rst_n(rst_n), .cfg_done_i(cfg_done), .loopback_i(loopback),
      .half_rate_i(half_rate), .enc_mode_i(enc_mode), .hw_rst_n_o(hw_rst_n_o),
      .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
      .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
      .tx_valid_o(tx_valid_o), .tx_k_o(tx_k_o), .tx_data_o(tx_data_o),
      .done_o(done_o), .err_o(err_o)
   );

   int checks = 0, failures = 0;
   txn_t exp_q[$];
   logic [8:0] tx_q[$];
   int fail_cfg[NTOT];
   int polls_seen[NTOT];
   bit stall = 0;
   int cyc = 0;
   bit poll_phase = 0, measuring = 0;
   int zeros_seen = 0, idle_cnt = 0;
   int tx_total = 0, tx_first = 0, tx_last = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic int ch_addr(input int g, input int ofs);
      return CH_BASE + (g / NCH) * QUAD_STRIDE + (g % NCH) * CH_STRIDE + ofs;
   endfunction

   function automatic int ch_of_addr(input int a);
      int r;
      r = a - CH_BASE;
      return (r / QUAD_STRIDE) * NCH + (r % QUAD_STRIDE) / CH_STRIDE;
   endfunction

   function automatic txn_t mk(input logic we, input int a, input int d, input string tag);
      txn_t t;
      t.we = we; t.addr = AW'(a); t.data = DW'(d); t.tag = tag;
      return t;
   endfunction

   // driver side: expected transactions and characters from the requirements
   task automatic build_expect(input bit lb, input bit hr, input bit enc, output bit want_err);
      int cfgv;
      exp_q.delete();
      tx_q.delete();
      want_err = 0;
      for (int g = 0; g < NTOT; g++) exp_q.push_back(mk(0, ch_addr(g, ALARM_OFS), 0, "R2"));
      for (int q = 0; q < NQUAD; q++) begin
         exp_q.push_back(mk(1, QCTL_BASE + q * QCTL_STRIDE, 'hFF, "R3"));
         exp_q.push_back(mk(1, QCTL_BASE + q * QCTL_STRIDE + 1, lb ? 'h0F : 'h00, "R3"));
      end
      cfgv = (int'(enc) << ENC_BIT) | (int'(hr) << HR_BIT);
      for (int g = 0; g < NTOT; g++) begin
         exp_q.push_back(mk(1, ch_addr(g, TXCFG_OFS), cfgv, "R4"));
         exp_q.push_back(mk(1, ch_addr(g, RXCFG_OFS), cfgv, "R4"));
      end
      exp_q.push_back(mk(1, GRST_ADDR, 1 << GRST_BIT, "R5"));
      exp_q.push_back(mk(1, GRST_ADDR, 1 << GRST_BIT, "R5"));
      exp_q.push_back(mk(1, GRST_ADDR, 0, "R5"));
      exp_q.push_back(mk(1, GRST_ADDR, 0, "R5"));
      for (int g = 0; g < NTOT && !want_err; g++) begin
         if (fail_cfg[g] >= MAXP) begin
            for (int k = 0; k < MAXP; k++) exp_q.push_back(mk(0, ch_addr(g, ALARM_OFS), 0, "R8"));
            want_err = 1;
         end else begin
            for (int k = 0; k <= fail_cfg[g]; k++) exp_q.push_back(mk(0, ch_addr(g, ALARM_OFS), 0, "R7"));
         end
      end
      if (!want_err && enc) begin
         for (int r = 0; r < 3; r++) begin
            tx_q.push_back({1'b1, 8'hBC});
            tx_q.push_back({1'b0, 8'h95});
            tx_q.push_back({1'b0, 8'hB5});
            tx_q.push_back({1'b0, 8'hB5});
         end
      end
   endtask

   // monitor side: bus slave, scoreboard, wait-gap measure, transmit capture
   always @(negedge clk) begin
      txn_t e;
      int g;
      logic [8:0] ec;
      cyc++;
      if (!rst_n) begin
         bus_ack = 0; bus_rdata = '0; poll_phase = 0; measuring = 0;
         zeros_seen = 0; idle_cnt = 0; tx_total = 0;
         for (int i = 0; i < NTOT; i++) polls_seen[i] = 0;
      end else begin
         if (measuring) begin
            if (!bus_req_o) idle_cnt++;
            else begin
               measuring = 0;
               check(idle_cnt == WAITC, "R6", "idle cycles before first poll", idle_cnt, WAITC);
            end
         end
         bus_ack = bus_req_o && !(stall && (cyc % 3 == 0));
         bus_rdata = '0;
         if (bus_ack) begin
            if (exp_q.size() == 0) begin
               check(0, "R8", "unexpected bus transaction addr", bus_addr_o, 0);
            end else begin
               e = exp_q.pop_front();
               check(bus_we_o == e.we && bus_addr_o == e.addr && (!e.we || bus_wdata_o == e.data),
                     e.tag, "bus transaction {we,addr,data}",
                     {bus_we_o, bus_addr_o, bus_wdata_o}, {e.we, e.addr, e.we ? e.data : bus_wdata_o});
            end
            if (!bus_we_o && poll_phase) begin
               g = ch_of_addr(int'(bus_addr_o));
               if (g >= 0 && g < NTOT) begin
                  if (polls_seen[g] >= fail_cfg[g]) bus_rdata[LOCK_BIT] = 1'b1;
                  polls_seen[g]++;
               end
            end
            if (bus_we_o && bus_addr_o == AW'(GRST_ADDR) && bus_wdata_o == '0) begin
               zeros_seen++;
               if (zeros_seen == 2) begin
                  poll_phase = 1; measuring = 1; idle_cnt = 0;
               end
            end
         end
         if (tx_valid_o) begin
            if (tx_total == 0) tx_first = cyc;
            tx_last = cyc;
            tx_total++;
            if (tx_q.size() == 0) begin
               check(0, "R9", "unexpected transmit character", {tx_k_o, tx_data_o}, 0);
            end else begin
               ec = tx_q.pop_front();
               check({tx_k_o, tx_data_o} == ec, "R9", "sync character {k,byte}", {tx_k_o, tx_data_o}, ec);
            end
         end
      end
   end

   task automatic run_case(input bit lb, input bit hr, input bit enc, input bit st);
      bit want_err, held;
      int n;
      rst_n = 0; cfg_done = 0;
      loopback = lb; half_rate = hr; enc_mode = enc; stall = st;
      build_expect(lb, hr, enc, want_err);
      repeat (3) @(negedge clk);
      check(!hw_rst_n_o && !bus_req_o && !done_o && !err_o && !tx_valid_o, "R1",
            "reset state {hw_rst_n,req,done,err,tx}",
            {hw_rst_n_o, bus_req_o, done_o, err_o, tx_valid_o}, 0);
      rst_n = 1;
      held = 1;
      repeat (10) begin
         @(negedge clk);
         if (hw_rst_n_o || bus_req_o) held = 0;
      end
      check(held, "R1", "reset held and bus idle while config pending", !held, 0);
      cfg_done = 1;
      @(negedge clk);
      check(hw_rst_n_o == 1'b1, "R1", "hardware reset released after config", hw_rst_n_o, 1);
      n = 0;
      while (!done_o && !err_o && n < 4000) begin
         @(negedge clk);
         n++;
      end
      check(n < 4000, "R12", "watchdog: sequence finished", n, 4000);
      repeat (20) @(negedge clk);
      check(err_o == want_err, want_err ? "R8" : "R7", "error flag", err_o, want_err);
      check(done_o == !want_err, enc ? "R9" : "R10", "done flag", done_o, !want_err);
      check(exp_q.size() == 0, "R7", "expected bus transactions left", exp_q.size(), 0);
      check(tx_q.size() == 0, "R9", "expected characters left", tx_q.size(), 0);
      if (enc && !want_err)
         check(tx_total == 12 && tx_last - tx_first == 11, "R9",
               "twelve characters on consecutive cycles", tx_last - tx_first + 1, 12);
      else
         check(tx_total == 0, enc ? "R8" : "R10", "no characters sent", tx_total, 0);
   endtask

   initial begin
      // all lock at once, plain options, no bus stalls
      for (int i = 0; i < NTOT; i++) fail_cfg[i] = 0;
      run_case(0, 0, 1, 0);
      // loopback and half rate, stalled bus (R11), lock on the last allowed poll
      for (int i = 0; i < NTOT; i++) fail_cfg[i] = 0;
      fail_cfg[2] = 2; fail_cfg[7] = MAXP - 1;
      run_case(1, 1, 1, 1);
      // 8b/10b off: no sync characters (R10)
      for (int i = 0; i < NTOT; i++) fail_cfg[i] = 0;
      fail_cfg[0] = 1;
      run_case(0, 1, 0, 0);
      // channel 5 never locks: error after MAX_POLLS reads (R8)
      for (int i = 0; i < NTOT; i++) fail_cfg[i] = 0;
      fail_cfg[5] = MAXP;
      run_case(1, 0, 1, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(10 * 150000);
      checks++;
      failures++;
      $display("FAIL R12 global watchdog expired: actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule